// File: doc/BRIEF.md
# Four-State Phase-Frequency Detector

This block compares the rising edges of a reference clock with those of a divided oscillator feedback clock. It drives an up pulse when the reference edge comes first and a down pulse when the feedback edge comes first. Each pulse lasts as long as the lead between the two edges. A fast system clock samples both inputs. A rising edge is a 0-to-1 change between two successive samples.

Two state bits drive the outputs. Two more bits record that a cycle slip has happened: a second reference edge came while up was already high, or the same on the down side. A slip bit swallows the next edge from the other input, so the leading output stays asserted. As a result, the detector steers the loop towards the faster input even when the two frequencies are far apart, and not only when the phase error is small.

A saturating signed counter adds up-cycles and subtracts down-cycles. It models the charge that the pump would deliver on average, which scales with the phase lead. Every pin is a plain level, because nothing at the edge of this block is a data stream.

Top module: `pfd_top`

## Requirements
- R1: When a reference edge reaches the detector D system cycles before a feedback edge, up_o goes high two clocks after ref_i rises. It stays high alone for exactly D cycles, then for one more cycle together with dn_o.
- R2: When the feedback edge leads by D cycles, dn_o behaves as R1 describes for up_o, with the roles of the two inputs swapped.
- R3: Whenever up_o and dn_o are both high, both are low in the next cycle. This is the only way the two outputs can overlap, and the overlap lasts one cycle. An input edge that arrives in that cycle is dropped.
- R4: If reference and feedback edges arrive in the same system cycle, the outputs do not change.
- R5: A reference edge that arrives while up_o is high sets an internal up-slip bit. The next feedback edge only clears that bit and does not raise dn_o. Further reference edges have no effect while the bit is set, so up_o stays high until a later feedback edge.
- R6: The down side mirrors R5, with the inputs and outputs exchanged.
- R7: pump_acc_o is a signed two's-complement counter. It adds 1 for each cycle in which only up_o is high and subtracts 1 for each cycle in which only dn_o is high, so an overlap cycle nets to zero. With the default 16-bit width it holds at 32767 and at -32768 rather than wrapping.
- R8: A synchronous active-high rst clears both outputs, both slip bits, the edge history and pump_acc_o to 0.
- R9: An input that stays high counts as a single edge. It does not set an output again after the overlap clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than either input |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock level |
| fb_i | input | 1 | Divided oscillator feedback level |
| up_o | output | 1 | Speed-up pulse |
| dn_o | output | 1 | Slow-down pulse |
| pump_acc_o | output | ACC_W | Signed net count of up-minus-down cycles |

## Verification
Two functions of this block can fall in the same cycle. The first is two input edges arriving together. The bench provokes this by pulsing both inputs on the same step and expects silent outputs and an unchanged count. The second is a new reference edge landing in the cycle where the overlap clear takes place. The bench times a reference pulse so that its edge reaches the detector exactly in the both-high cycle. It then expects both outputs low from the next cycle onward and a count that grew only by the original lead.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
    logic up_slip;
    logic dn_slip;
  } pfd_state_t;

  localparam int unsigned PFD_NUM_IN = 2;
  localparam int unsigned PFD_REF    = 0;
  localparam int unsigned PFD_FB     = 1;
endpackage

// File: rtl/pfd_edge_sampler.sv
module pfd_edge_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic now_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        now_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        now_q  <= lvl_i[g];
        prev_q <= now_q;
      end
    end
    assign rise_o[g] = now_q & ~prev_q;

    // R9: a detected edge never lasts two cycles
    assert_single_edge_R9: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_rise,
  input  logic       fb_rise,
  output pfd_state_t st_o
);
  pfd_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q.up && st_q.dn) begin
      st_d.up = 1'b0;
      st_d.dn = 1'b0;
    end else if (ref_rise && fb_rise) begin
      st_d = st_q;
    end else if (ref_rise) begin
      if (st_q.dn_slip)      st_d.dn_slip = 1'b0;
      else if (st_q.up)      st_d.up_slip = 1'b1;
      else                   st_d.up      = 1'b1;
    end else if (fb_rise) begin
      if (st_q.up_slip)      st_d.up_slip = 1'b0;
      else if (st_q.dn)      st_d.dn_slip = 1'b1;
      else                   st_d.dn      = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

  assign st_o = st_q;

  assert_overlap_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q.up && st_q.dn) |=> (!st_q.up && !st_q.dn));
  assert_coincident_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise && !(st_q.up && st_q.dn)) |=> $stable(st_q));
  assert_ref_sets_up_R1: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && !fb_rise && !st_q.up && !st_q.dn && !st_q.dn_slip) |=> st_q.up);
  assert_fb_sets_dn_R2: assert property (@(posedge clk) disable iff (rst)
    (fb_rise && !ref_rise && !st_q.up && !st_q.dn && !st_q.up_slip) |=> st_q.dn);
  assert_up_slip_holds_up_R5: assert property (@(posedge clk) disable iff (rst)
    st_q.up_slip |-> (st_q.up && !st_q.dn_slip));
  assert_dn_slip_holds_dn_R6: assert property (@(posedge clk) disable iff (rst)
    st_q.dn_slip |-> (st_q.dn && !st_q.up_slip));
endmodule

// File: rtl/pfd_pump_acc.sv
module pfd_pump_acc #(
  parameter int unsigned ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up,
  input  logic                    dn,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (up && !dn && acc_q != ACC_MAX)      acc_d = acc_q + ACC_ONE;
    else if (dn && !up && acc_q != ACC_MIN) acc_d = acc_q - ACC_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_no_wrap_high_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_MAX && up && !dn) |=> acc_q == ACC_MAX);
  assert_no_wrap_low_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_q == ACC_MIN && dn && !up) |=> acc_q == ACC_MIN);
  assert_step_up_R7: assert property (@(posedge clk) disable iff (rst)
    (up && !dn && acc_q != ACC_MAX) |=> acc_q == $past(acc_q) + ACC_ONE);
  assert_overlap_neutral_R7: assert property (@(posedge clk) disable iff (rst)
    (up == dn) |=> $stable(acc_q));
endmodule

// File: rtl/pfd_top.sv
module pfd_top
  import pfd_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_i,
  input  logic                    fb_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [ACC_W-1:0] pump_acc_o
);
  logic [PFD_NUM_IN-1:0] rise;
  pfd_state_t            st;

  pfd_edge_sampler #(.N(PFD_NUM_IN)) u_edges (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({fb_i, ref_i}),
    .rise_o (rise)
  );

  pfd_core u_core (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[PFD_REF]),
    .fb_rise  (rise[PFD_FB]),
    .st_o     (st)
  );

  pfd_pump_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .up    (st.up),
    .dn    (st.dn),
    .acc_o (pump_acc_o)
  );

  assign up_o = st.up;
  assign dn_o = st.dn;
endmodule

// File: tb/tb_pfd_top.sv
module tb_pfd_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_i = 1'b0;
  logic fb_i = 1'b0;
  logic up_o, dn_o;
  logic signed [15:0] pump_acc_o;

  always #10 clk = ~clk;

  pfd_top #(.ACC_W(16)) dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
    .up_o(up_o), .dn_o(dn_o), .pump_acc_o(pump_acc_o)
  );

  typedef struct {
    int    cyc;
    logic  up;
    logic  dn;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int bad = 0;
  int exp_acc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected output pairs and compares them at their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || up_o !== e.up || dn_o !== e.dn) begin
        bad++;
        $display("FAIL %s cyc=%0d up,dn actual=%b%b expected=%b%b",
                 e.tag, cyc, up_o, dn_o, e.up, e.dn);
      end
    end
  end

  task automatic expect_rng(input int a, input int b, input logic u, input logic d,
                            input string tag);
    for (int k = a; k <= b; k++) begin
      exp_t e;
      e.cyc = k; e.up = u; e.dn = d; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one step per negedge; the first step is driven at the current negedge
  task automatic play(input longint rm, input longint fm, input int len);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      ref_i = rm[k];
      fb_i  = fm[k];
    end
  endtask

  task automatic idle(input int n);
    ref_i = 1'b0;
    fb_i  = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // leader held high for 'hold' steps, lagger pulsed at step d
  task automatic lead(input bit ref_first, input int d, input int hold, input string tag);
    int c;
    longint lm, gm;
    @(negedge clk);
    c  = cyc;
    lm = (64'sd1 <<< hold) - 64'sd1;
    gm = 64'sd1 <<< d;
    expect_rng(c + 2, c + d + 1, ref_first, !ref_first, tag);
    expect_rng(c + d + 2, c + d + 2, 1'b1, 1'b1, tag);
    expect_rng(c + d + 3, c + d + 5, 1'b0, 1'b0, tag);
    if (ref_first) play(lm, gm, d + 6);
    else           play(gm, lm, d + 6);
    idle(2);
    exp_acc += ref_first ? d : -d;
    chk({tag, " acc"}, pump_acc_o, exp_acc);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8 up", up_o, 0);
    chk("R8 dn", dn_o, 0);
    chk("R8 acc", pump_acc_o, 0);

    lead(1'b1, 4, 1, "R1");
    lead(1'b0, 3, 1, "R2");
    lead(1'b1, 1, 1, "R1 short");
    lead(1'b1, 3, 6, "R9 ref held");
    lead(1'b0, 5, 7, "R9 fb held");

    // R4 coincident edges
    @(negedge clk); c = cyc;
    expect_rng(c + 2, c + 5, 1'b0, 1'b0, "R4");
    play(64'h1, 64'h1, 6);
    idle(2);
    chk("R4 acc", pump_acc_o, exp_acc);

    // R3 reference edge landing in the overlap-clear cycle is dropped
    @(negedge clk); c = cyc;
    expect_rng(c + 2, c + 3, 1'b1, 1'b0, "R3");
    expect_rng(c + 4, c + 4, 1'b1, 1'b1, "R3");
    expect_rng(c + 5, c + 8, 1'b0, 1'b0, "R3 drop");
    play(64'h9, 64'h4, 9);
    idle(2);
    exp_acc += 2;
    chk("R3 acc", pump_acc_o, exp_acc);

    // R5 reference faster: slip absorbs first feedback edge
    @(negedge clk); c = cyc;
    expect_rng(c + 2, c + 13, 1'b1, 1'b0, "R5");
    expect_rng(c + 14, c + 14, 1'b1, 1'b1, "R5");
    expect_rng(c + 15, c + 17, 1'b0, 1'b0, "R5");
    play(64'h49, 64'h1200, 18);
    idle(2);
    exp_acc += 12;
    chk("R5 acc", pump_acc_o, exp_acc);

    // R6 feedback faster
    @(negedge clk); c = cyc;
    expect_rng(c + 2, c + 11, 1'b0, 1'b1, "R6");
    expect_rng(c + 12, c + 12, 1'b1, 1'b1, "R6");
    expect_rng(c + 13, c + 15, 1'b0, 1'b0, "R6");
    play(64'h480, 64'h9, 16);
    idle(2);
    exp_acc -= 10;
    chk("R6 acc", pump_acc_o, exp_acc);

    // R8 reset while up is asserted
    play(64'h1, 64'h0, 2);
    idle(3);
    chk("R8 up before reset", up_o, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 up after reset", up_o, 0);
    chk("R8 acc after reset", pump_acc_o, 0);
    idle(2);
    chk("R8 up stays low", up_o, 0);

    // R7 saturation high then low
    play(64'h1, 64'h0, 2);
    idle(32800);
    chk("R7 max", pump_acc_o, 32767);
    chk("R7 up held", up_o, 1);
    play(64'h0, 64'h1, 2);
    idle(10);
    chk("R7 max after overlap", pump_acc_o, 32767);
    chk("R7 cleared", {up_o, dn_o}, 0);
    play(64'h0, 64'h1, 2);
    idle(65600);
    chk("R7 min", pump_acc_o, -32768);
    chk("R7 dn held", dn_o, 1);
    play(64'h1, 64'h0, 2);
    idle(10);
    chk("R7 min after overlap", pump_acc_o, -32768);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule